// File: doc/BRIEF.md
# USB Host Pipe Bank Controller

This block manages the data banks of a single USB host pipe, shared between a packet engine and a CPU-side register interface. Each bank is a small byte store with its own fill count, drain index, event flag and owner. A bank always belongs either to the packet engine or to the CPU. In the receive direction (`IS_IN = 1`), the packet engine fills a bank with an incoming packet and the CPU drains it through a byte read port. In the transmit direction (`IS_IN = 0`), the CPU fills a bank through a byte write port and the packet engine reads it out and sends it. With two banks, the two sides work on different banks at the same time. Each side has its own pointer, and each pointer steps round-robin over the banks.

Every bank runs a two-state ownership machine. The states are `OWN_PKT` (the packet engine holds the bank) and `OWN_CPU` (the CPU holds the bank). The transition `HANDOVER_TO_CPU` fires when the packet engine signals packet end on the bank it holds. The transition `RELEASE_TO_PKT` fires when the CPU accepts a FIFO-control clear on the bank it holds. When a bank enters the state of the side that fills it, its count and index return to zero. The CPU-visible flags always show the bank under the CPU pointer. After a release moves that pointer, the flags therefore show the next bank.

The packet side acts only while the pipe is configured and not frozen. The CPU side is never gated.

Top module: `usb_pipe_bank_ctrl`

## Requirements
- R1: After reset, in the receive direction, `fifocon_flag`, `evt_flag`, `rw_allowed` and `irq` are 0. In the transmit direction, `fifocon_flag` and `rw_allowed` are 1, while `evt_flag` and `pkt_bank_ready` are 0.
- R2: While `cfg_ok` is 0 or `frozen` is 1, `pkt_bank_ready` is 0, and `pkt_wr_en`, `pkt_rd_en` and `pkt_done` have no effect on any bank.
- R3: In the receive direction, `pkt_done` on a bank held by the packet side hands that bank to the CPU and sets that bank's event flag. When the bank is under the CPU pointer, `evt_flag` and `fifocon_flag` both read 1 after the next clock edge.
- R4: `fifocon_clr` is accepted when `fifocon_flag` is 1 and `evt_flag` is 0. An accepted clear returns the bank to the packet side and, with two banks, moves the CPU pointer to the other bank. After the edge, the flags and the data port reflect that other bank.
- R5: `fifocon_clr` is ignored while `evt_flag` is 1. The same bank stays with the CPU and its read position does not change.
- R6: In the receive direction, `rw_allowed` is 1 exactly when the CPU holds the current bank and that bank has unread bytes. `cpu_rd_data` shows the next byte in the order the bytes were received, and each `cpu_rd_en` advances to the following byte.
- R7: In the transmit direction, `rw_allowed` is 1 while the CPU holds the current bank and it has fewer than `BANK_BYTES` bytes. A clear hands over even a partly filled bank. The packet side then sees its length on `pkt_byte_count` and its bytes in write order on `pkt_rd_data`.
- R8: In the transmit direction, `pkt_done` on a bank held by the packet side returns the bank to the CPU. Its transmitted-data event flag and its FIFO-control flag become 1 on the same edge.
- R9: `irq` is 1 exactly when `evt_flag` is 1 and `int_en` is 1.
- R10: A read from a bank with no unread bytes returns 0 and does not move the index. A write to a full bank is dropped and the count stays at `BANK_BYTES`.
- R11: `evt_set` sets and `evt_clr` clears the event flag of the bank under the CPU pointer. When both are pulsed in the same cycle, the set wins.
- R12: With two banks, the packet pointer alternates between banks. When the CPU holds both banks in the receive direction, `pkt_bank_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ok | input | 1 | Pipe is configured |
| frozen | input | 1 | Pipe is frozen; packet side is stalled |
| pkt_wr_en | input | 1 | Packet side writes one received byte (receive direction) |
| pkt_wr_data | input | DATA_W | Received byte |
| pkt_rd_en | input | 1 | Packet side consumes one byte to send (transmit direction) |
| pkt_rd_data | output | DATA_W | Next byte to send, 0 when none |
| pkt_done | input | 1 | Packet end on the packet side's current bank |
| pkt_bank_ready | output | 1 | Packet side holds its current bank and the pipe is active |
| pkt_byte_count | output | CW | Byte count of the packet side's current bank |
| cpu_wr_en | input | 1 | CPU writes one byte (transmit direction) |
| cpu_wr_data | input | DATA_W | CPU write byte |
| cpu_rd_en | input | 1 | CPU consumes one byte (receive direction) |
| cpu_rd_data | output | DATA_W | Next unread byte, 0 when none |
| evt_set | input | 1 | Set strobe for the current bank's event flag |
| evt_clr | input | 1 | Clear strobe for the current bank's event flag |
| fifocon_clr | input | 1 | FIFO-control clear strobe: release current bank |
| int_en | input | 1 | Interrupt enable for the event flag |
| evt_flag | output | 1 | Received-data or transmitted-data flag of the current CPU bank |
| fifocon_flag | output | 1 | CPU holds the current bank |
| rw_allowed | output | 1 | CPU may read (receive) or write (transmit) the current bank |
| irq | output | 1 | Pipe interrupt |

## Verification
The hardest state to reach is the one where the two pointers disagree. In the receive direction the CPU must hold both banks at once. In the transmit direction the CPU pointer must sit on a bank that the packet side still holds. Only in these states do a refused clear, the reload of the flags from the other bank, and a stalled `pkt_bank_ready` become visible. The directed tasks reach them as follows. In the receive direction, two packets are delivered back to back before the CPU releases anything. In the transmit direction, both banks are filled and released before the engine sends. In both cases the flag is held set so the clear is refused. Freeze is then applied across a pending `pkt_done` to show that the packet side stands still.

// File: rtl/upb_pkg.sv
package upb_pkg;

    // Owner of one data bank
    typedef enum logic {
        OWN_PKT = 1'b0,
        OWN_CPU = 1'b1
    } bank_own_e;

endpackage

// File: rtl/upb_rr_ptr.sv
module upb_rr_ptr #(
    parameter int N  = 2,
    parameter int PW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);

    // Round-robin bank pointer; stays at zero when N is one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == PW'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/upb_bank.sv
module upb_bank
    import upb_pkg::*;
#(
    parameter int        DATA_W  = 8,
    parameter int        DEPTH   = 8,
    parameter int        CW      = 4,
    parameter bank_own_e FILL_OWN = OWN_PKT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              to_cpu,
    input  logic              to_pkt,
    input  logic              fill_we,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              drain_re,
    input  logic              evt_set_i,
    input  logic              evt_clr_i,
    output bank_own_e         own,
    output logic [CW-1:0]     cnt,
    output logic [DATA_W-1:0] drain_data,
    output logic              evt,
    output logic              is_full,
    output logic              has_unread
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    bank_own_e         state_q, state_d;
    logic [CW-1:0]     idx;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              enter_fill;

    // Ownership state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_OWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: HANDOVER_TO_CPU and RELEASE_TO_PKT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_PKT: if (to_cpu) state_d = OWN_CPU;
            OWN_CPU: if (to_pkt) state_d = OWN_PKT;
            default: state_d = FILL_OWN;
        endcase
    end

    // Outputs of the bank
    always_comb begin
        own        = state_q;
        is_full    = (cnt == CW'(DEPTH));
        has_unread = (idx < cnt);
        drain_data = mem[idx[AW-1:0]];
        enter_fill = (state_q != FILL_OWN) && (state_d == FILL_OWN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            idx <= '0;
            evt <= 1'b0;
        end else begin
            if (enter_fill) begin
                cnt <= '0;
                idx <= '0;
            end else begin
                if (fill_we && !is_full)     cnt <= cnt + 1'b1;
                if (drain_re && has_unread)  idx <= idx + 1'b1;
            end
            if (evt_set_i)      evt <= 1'b1;
            else if (evt_clr_i) evt <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we && !is_full) begin
            mem[cnt[AW-1:0]] <= fill_data;
        end
    end

endmodule

// File: rtl/usb_pipe_bank_ctrl.sv
module usb_pipe_bank_ctrl
    import upb_pkg::*;
#(
    parameter bit IS_IN      = 1'b1,
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int CW        = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ok,
    input  logic              frozen,
    input  logic              pkt_wr_en,
    input  logic [DATA_W-1:0] pkt_wr_data,
    input  logic              pkt_rd_en,
    output logic [DATA_W-1:0] pkt_rd_data,
    input  logic              pkt_done,
    output logic              pkt_bank_ready,
    output logic [CW-1:0]     pkt_byte_count,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    input  logic              evt_set,
    input  logic              evt_clr,
    input  logic              fifocon_clr,
    input  logic              int_en,
    output logic              evt_flag,
    output logic              fifocon_flag,
    output logic              rw_allowed,
    output logic              irq
);

    localparam int        PW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam bank_own_e FILL_OWN = IS_IN ? OWN_PKT : OWN_CPU;

    logic [PW-1:0]     pkt_ptr, cpu_ptr;
    logic              active;
    logic              cpu_own, pkt_own;
    logic              pd_ok, fc_ok;
    logic              fill_any, drain_any;
    logic [DATA_W-1:0] fill_data;

    bank_own_e         own_a    [NUM_BANKS];
    logic [CW-1:0]     cnt_a    [NUM_BANKS];
    logic [DATA_W-1:0] dd_a     [NUM_BANKS];
    logic              evt_a    [NUM_BANKS];
    logic              full_a   [NUM_BANKS];
    logic              unread_a [NUM_BANKS];

    always_comb begin
        active    = cfg_ok && !frozen;
        cpu_own   = (own_a[cpu_ptr] == OWN_CPU);
        pkt_own   = (own_a[pkt_ptr] == OWN_PKT);
        pd_ok     = pkt_done && active && pkt_own;
        fc_ok     = fifocon_clr && cpu_own && !evt_a[cpu_ptr];
        fill_any  = IS_IN ? (pkt_wr_en && active && pkt_own) : (cpu_wr_en && cpu_own);
        drain_any = IS_IN ? (cpu_rd_en && cpu_own) : (pkt_rd_en && active && pkt_own);
        fill_data = IS_IN ? pkt_wr_data : cpu_wr_data;
    end

    upb_rr_ptr #(.N(NUM_BANKS), .PW(PW)) u_pkt_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pd_ok),
        .ptr   (pkt_ptr)
    );

    upb_rr_ptr #(.N(NUM_BANKS), .PW(PW)) u_cpu_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fc_ok),
        .ptr   (cpu_ptr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic on_cpu, on_pkt;
        logic fill_sel, drain_sel;

        always_comb begin
            on_cpu    = (cpu_ptr == PW'(b));
            on_pkt    = (pkt_ptr == PW'(b));
            fill_sel  = IS_IN ? on_pkt : on_cpu;
            drain_sel = IS_IN ? on_cpu : on_pkt;
        end

        upb_bank #(
            .DATA_W   (DATA_W),
            .DEPTH    (BANK_BYTES),
            .CW       (CW),
            .FILL_OWN (FILL_OWN)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .to_cpu     (pd_ok && on_pkt),
            .to_pkt     (fc_ok && on_cpu),
            .fill_we    (fill_any && fill_sel),
            .fill_data  (fill_data),
            .drain_re   (drain_any && drain_sel),
            .evt_set_i  ((pd_ok && on_pkt) || (evt_set && on_cpu)),
            .evt_clr_i  (evt_clr && on_cpu),
            .own        (own_a[b]),
            .cnt        (cnt_a[b]),
            .drain_data (dd_a[b]),
            .evt        (evt_a[b]),
            .is_full    (full_a[b]),
            .has_unread (unread_a[b])
        );
    end

    // Port outputs, all taken from the bank under the relevant pointer
    always_comb begin
        fifocon_flag   = cpu_own;
        evt_flag       = evt_a[cpu_ptr];
        irq            = evt_a[cpu_ptr] && int_en;
        pkt_bank_ready = active && pkt_own;
        pkt_byte_count = cnt_a[pkt_ptr];
        if (IS_IN) begin
            rw_allowed  = cpu_own && unread_a[cpu_ptr];
            cpu_rd_data = rw_allowed ? dd_a[cpu_ptr] : '0;
            pkt_rd_data = '0;
        end else begin
            rw_allowed  = cpu_own && !full_a[cpu_ptr];
            cpu_rd_data = '0;
            pkt_rd_data = (pkt_bank_ready && unread_a[pkt_ptr]) ? dd_a[pkt_ptr] : '0;
        end
    end

endmodule

// File: rtl/upb_checker.sv
module upb_checker #(
    parameter bit IS_IN      = 1'b1,
    parameter int BANK_BYTES = 8,
    parameter int DATA_W     = 8,
    parameter int CW         = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ok,
    input logic              frozen,
    input logic              fifocon_clr,
    input logic              evt_clr,
    input logic              cpu_wr_en,
    input logic              int_en,
    input logic              evt_flag,
    input logic              fifocon_flag,
    input logic              rw_allowed,
    input logic              irq,
    input logic              pkt_bank_ready,
    input logic [CW-1:0]     pkt_byte_count,
    input logic [DATA_W-1:0] cpu_rd_data
);

    logic idle_pipe;
    assign idle_pipe = !cfg_ok || frozen;

    assert_frozen_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_pipe |-> !pkt_bank_ready);

    assert_frozen_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_pipe && !fifocon_clr && !cpu_wr_en) |=> $stable(pkt_byte_count));

    assert_fc_fall_needs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fifocon_flag) |-> $past(fifocon_clr));

    assert_fc_clear_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifocon_clr && evt_flag && !evt_clr) |=> (fifocon_flag && evt_flag));

    assert_rw_needs_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rw_allowed |-> fifocon_flag);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);

    assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_byte_count <= CW'(BANK_BYTES));

    if (IS_IN) begin : g_in_chk
        assert_empty_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !rw_allowed |-> (cpu_rd_data == '0));
    end

endmodule

bind usb_pipe_bank_ctrl upb_checker #(
    .IS_IN      (IS_IN),
    .BANK_BYTES (BANK_BYTES),
    .DATA_W     (DATA_W),
    .CW         (CW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_ok         (cfg_ok),
    .frozen         (frozen),
    .fifocon_clr    (fifocon_clr),
    .evt_clr        (evt_clr),
    .cpu_wr_en      (cpu_wr_en),
    .int_en         (int_en),
    .evt_flag       (evt_flag),
    .fifocon_flag   (fifocon_flag),
    .rw_allowed     (rw_allowed),
    .irq            (irq),
    .pkt_bank_ready (pkt_bank_ready),
    .pkt_byte_count (pkt_byte_count),
    .cpu_rd_data    (cpu_rd_data)
);

// File: tb/sim_usb_pipe_bank_ctrl.sv
`timescale 1ns/1ps
module sim_usb_pipe_bank_ctrl;

    localparam int DW = 8;
    localparam int BB = 4;
    localparam int CW = $clog2(BB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // receive-direction DUT signals (i_) and transmit-direction DUT signals (o_)
    logic          i_cfg = 0, i_frz = 0, i_pwr = 0, i_prd = 0, i_pdone = 0;
    logic [DW-1:0] i_pwd = 0, i_cwd = 0;
    logic          i_cwr = 0, i_crd = 0, i_eset = 0, i_eclr = 0, i_fcc = 0, i_ien = 0;
    logic [DW-1:0] i_prdd, i_crdd;
    logic [CW-1:0] i_cnt;
    logic          i_rdy, i_evt, i_fc, i_rw, i_irq;

    logic          o_cfg = 0, o_frz = 0, o_pwr = 0, o_prd = 0, o_pdone = 0;
    logic [DW-1:0] o_pwd = 0, o_cwd = 0;
    logic          o_cwr = 0, o_crd = 0, o_eset = 0, o_eclr = 0, o_fcc = 0, o_ien = 0;
    logic [DW-1:0] o_prdd, o_crdd;
    logic [CW-1:0] o_cnt;
    logic          o_rdy, o_evt, o_fc, o_rw, o_irq;

    usb_pipe_bank_ctrl #(.IS_IN(1'b1), .NUM_BANKS(2), .BANK_BYTES(BB), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ok(i_cfg), .frozen(i_frz),
        .pkt_wr_en(i_pwr), .pkt_wr_data(i_pwd), .pkt_rd_en(i_prd), .pkt_rd_data(i_prdd),
        .pkt_done(i_pdone), .pkt_bank_ready(i_rdy), .pkt_byte_count(i_cnt),
        .cpu_wr_en(i_cwr), .cpu_wr_data(i_cwd), .cpu_rd_en(i_crd), .cpu_rd_data(i_crdd),
        .evt_set(i_eset), .evt_clr(i_eclr), .fifocon_clr(i_fcc), .int_en(i_ien),
        .evt_flag(i_evt), .fifocon_flag(i_fc), .rw_allowed(i_rw), .irq(i_irq));

    usb_pipe_bank_ctrl #(.IS_IN(1'b0), .NUM_BANKS(2), .BANK_BYTES(BB), .DATA_W(DW)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_ok(o_cfg), .frozen(o_frz),
        .pkt_wr_en(o_pwr), .pkt_wr_data(o_pwd), .pkt_rd_en(o_prd), .pkt_rd_data(o_prdd),
        .pkt_done(o_pdone), .pkt_bank_ready(o_rdy), .pkt_byte_count(o_cnt),
        .cpu_wr_en(o_cwr), .cpu_wr_data(o_cwd), .cpu_rd_en(o_crd), .cpu_rd_data(o_crdd),
        .evt_set(o_eset), .evt_clr(o_eclr), .fifocon_clr(o_fcc), .int_en(o_ien),
        .evt_flag(o_evt), .fifocon_flag(o_fc), .rw_allowed(o_rw), .irq(o_irq));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Hold the strobes set by the caller for one edge, then drop them
    task automatic tick();
        @(negedge clk);
        i_pwr = 0; i_prd = 0; i_pdone = 0; i_cwr = 0; i_crd = 0;
        i_eset = 0; i_eclr = 0; i_fcc = 0;
        o_pwr = 0; o_prd = 0; o_pdone = 0; o_cwr = 0; o_crd = 0;
        o_eset = 0; o_eclr = 0; o_fcc = 0;
        #1;
    endtask

    task automatic in_byte(input logic [DW-1:0] d);
        i_pwr = 1; i_pwd = d; tick();
    endtask

    task automatic out_byte(input logic [DW-1:0] d);
        o_cwr = 1; o_cwd = d; tick();
    endtask

    task automatic t_reset();
        chk("R1", "in fifocon", i_fc, 0);
        chk("R1", "in evt", i_evt, 0);
        chk("R1", "in rw", i_rw, 0);
        chk("R1", "in irq", i_irq, 0);
        chk("R1", "out fifocon", o_fc, 1);
        chk("R1", "out rw", o_rw, 1);
        chk("R1", "out evt", o_evt, 0);
        chk("R1", "out ready", o_rdy, 0);
    endtask

    task automatic t_in_frozen();
        i_cfg = 1; i_frz = 1; #1;
        chk("R2", "frozen ready", i_rdy, 0);
        in_byte(8'h5A);
        i_pdone = 1; tick();
        chk("R2", "frozen count", i_cnt, 0);
        chk("R2", "frozen fifocon", i_fc, 0);
        i_frz = 0; #1;
        chk("R2", "unfrozen ready", i_rdy, 1);
    endtask

    task automatic t_in_two_packets();
        in_byte(8'hA1); in_byte(8'hA2); in_byte(8'hA3);
        chk("R3", "count before end", i_cnt, 3);
        i_pdone = 1; tick();
        chk("R3", "evt after end", i_evt, 1);
        chk("R3", "fifocon after end", i_fc, 1);
        chk("R6", "rw with data", i_rw, 1);
        chk("R6", "first byte", i_crdd, 8'hA1);
        chk("R9", "irq masked", i_irq, 0);
        i_ien = 1; #1;
        chk("R9", "irq enabled", i_irq, 1);
        chk("R12", "second bank ready", i_rdy, 1);
        chk("R12", "second bank empty", i_cnt, 0);
        in_byte(8'hB1);
        i_pdone = 1; tick();
        chk("R12", "both banks with cpu", i_rdy, 0);
        in_byte(8'hCC);
        chk("R12", "write refused", i_cnt, 3);
    endtask

    task automatic t_in_drain_release();
        i_fcc = 1; tick();
        chk("R5", "clear refused fifocon", i_fc, 1);
        chk("R5", "clear refused data", i_crdd, 8'hA1);
        i_crd = 1; tick();
        chk("R6", "second byte", i_crdd, 8'hA2);
        i_crd = 1; tick();
        chk("R6", "third byte", i_crdd, 8'hA3);
        i_crd = 1; tick();
        chk("R6", "rw drained", i_rw, 0);
        chk("R10", "empty read zero", i_crdd, 0);
        i_crd = 1; tick();
        chk("R10", "empty read stays", i_crdd, 0);
        chk("R10", "empty rw stays", i_rw, 0);
        i_eclr = 1; tick();
        chk("R11", "evt cleared", i_evt, 0);
        chk("R9", "irq follows evt", i_irq, 0);
        i_fcc = 1; tick();
        chk("R4", "next bank fifocon", i_fc, 1);
        chk("R4", "next bank evt", i_evt, 1);
        chk("R4", "next bank data", i_crdd, 8'hB1);
        chk("R4", "released bank ready", i_rdy, 1);
        chk("R4", "released bank count", i_cnt, 0);
        i_eclr = 1; i_eset = 1; tick();
        chk("R11", "set wins", i_evt, 1);
    endtask

    task automatic t_out_fill_send();
        o_cfg = 1; #1;
        out_byte(8'hC1); out_byte(8'hC2); out_byte(8'hC3);
        chk("R7", "rw not full", o_rw, 1);
        out_byte(8'hC4);
        chk("R7", "rw full", o_rw, 0);
        out_byte(8'hEE);
        o_fcc = 1; tick();
        chk("R10", "full write dropped", o_cnt, 4);
        chk("R7", "bank to engine", o_rdy, 1);
        chk("R4", "other bank free", o_fc, 1);
        chk("R7", "first byte out", o_prdd, 8'hC1);
        for (int k = 1; k < 4; k++) begin
            o_prd = 1; tick();
            chk("R7", "byte out order", o_prdd, 32'(8'hC1 + k));
        end
        o_prd = 1; tick();
        chk("R10", "engine empty read zero", o_prdd, 0);
        out_byte(8'hD1); out_byte(8'hD2);
        o_fcc = 1; tick();
        chk("R7", "partial release fifocon", o_fc, 0);
        chk("R7", "partial release rw", o_rw, 0);
        o_frz = 1; o_pdone = 1; tick();
        chk("R2", "frozen send ignored", o_fc, 0);
        o_frz = 0; o_ien = 1; o_pdone = 1; tick();
        chk("R8", "tx evt", o_evt, 1);
        chk("R8", "tx fifocon", o_fc, 1);
        chk("R9", "tx irq", o_irq, 1);
        chk("R7", "partial bank length", o_cnt, 2);
        chk("R7", "partial bank first", o_prdd, 8'hD1);
        o_fcc = 1; tick();
        chk("R5", "tx clear refused", o_fc, 1);
        chk("R7", "freed bank writable", o_rw, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        t_reset();
        t_in_frozen();
        t_in_two_packets();
        t_in_drain_release();
        t_out_fill_send();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule